// File: doc/BRIEF.md
# Serial Port Holding Buffer and Frame Sync Controller

This block sits between a host register interface and the pins of a framed serial port. In transmit mode the host writes one word into a transmit holding buffer. On each frame sync the word moves into a shift register and goes out most significant bit first, one bit per serial bit strobe. In receive mode the block collects one word per frame from the data pin into a receive holding buffer, and the host reads it from there.

Frame sync comes either from outside or from an internal period counter. With internal sync in transmit mode, the sync can depend on data: a period boundary that finds the buffer empty produces no sync. It can also run freely, firing on every boundary. Free running needs both the free-run control bit and the multichannel control bit. Two sticky error flags report a transmit underflow, meaning a sync met an empty buffer, and a receive overflow, meaning a word arrived while the previous one was unread. On overflow the new word replaces the held one.

The serial clock enters as a one-cycle bit strobe (`sclkTick`) in the system clock domain. Word length is fixed by the parameter `WORD_W`, 16 by default.

Top module: `serbuf_top`

## Requirements
- R1: After reset, every host register reads 0, both buffers are empty, both flags are clear, and `sdOut` and `fsOut` are 0. Host registers are: address 0 control (bit0 enable, bit1 transmit mode, bit2 internal sync, bit3 multichannel, bit4 free-run sync); address 1 period; address 2 data; address 3 status on read and command on write.
- R2: Status bit0 is "transmit buffer full". While the port is enabled, a write to address 2 sets it. A frame sync that moves the word into the shift register clears it. A write to address 2 while the port is disabled has no effect.
- R3: In transmit mode the word loaded at a sync appears on `sdOut` MSB first. The MSB is visible in the cycle after the sync strobe. Each later strobe advances one bit, and after the last bit `sdOut` is 0.
- R4: With internal sync, period boundaries fall every max(period, `WORD_W`) strobes, and the first boundary falls on the first strobe after enable. When a sync fires, `fsOut` goes high in the next cycle and falls after the next strobe.
- R5: With internal sync in transmit mode, and free-run not in effect, a boundary that finds the transmit buffer empty produces no sync and no underflow. Free-run is in effect only when bits 4 and 3 are both set.
- R6: When free-run is in effect, a sync fires on every boundary. A sync that finds the buffer empty sends an all-zero word and sets the underflow flag.
- R7: Status bit2 (underflow) is set by any sync, internal or external, that finds the transmit buffer empty. With an external sync, `sdOut` stays 0 for that frame.
- R8: In receive mode the bit on `sdIn` at the sync strobe is the MSB, and `WORD_W` strobes complete a word. The finished word goes to the receive buffer and sets status bit1. A read of address 2 returns the word and clears bit1.
- R9: A word that completes while status bit1 is still set sets status bit3 (overflow) and replaces the held word.
- R10: Both flags are sticky. Writing 1 to command bit0 clears underflow, writing 1 to command bit1 clears overflow, and disabling the port clears both. A command write of 0 or a control write clears neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe (side effect on address 2) |
| hostAddr | input | 2 | Host register address |
| hostWdata | input | HOST_W | Host write data |
| hostRdata | output | HOST_W | Host read data, combinational on address |
| sclkTick | input | 1 | One-cycle serial bit strobe |
| fsIn | input | 1 | External frame sync, sampled on a strobe |
| fsOut | output | 1 | Internally generated frame sync |
| sdIn | input | 1 | Serial receive data |
| sdOut | output | 1 | Serial transmit data |

## Verification
Assertions check on every cycle the local cause and effect of each event: a host write fills the transmit buffer, a load empties it, an empty-buffer sync raises underflow and silences the data pin, a completed word fills the receive buffer, an unread word raises overflow, flags hold until cleared, and `fsOut` never rises on an empty buffer in data-dependent mode. Only the bench's scenarios can show end-to-end properties. These are the exact bit order on `sdOut`, the sync spacing with the period clamp applied, that overflow leaves the newest word in the buffer, and that writes while disabled or command writes of 0 leave the state unchanged.

// File: rtl/serbuf_pkg.sv
package serbuf_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PER  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int CTRL_W     = 5;
  localparam int BIT_EN     = 0;
  localparam int BIT_TX     = 1;
  localparam int BIT_INTSYN = 2;
  localparam int BIT_MC     = 3;
  localparam int BIT_FREE   = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic en;
    logic tick;
    logic txLoad;
    logic rxStart;
    logic hostTxWr;
    logic hostRxRd;
  } serbufStrobeT;
endpackage

// File: rtl/serbuf_ctrl.sv
module serbuf_ctrl
  import serbuf_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int PER_W  = 8,
  parameter int HOST_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [1:0]        hostAddr,
  input  logic [HOST_W-1:0] hostWdata,
  output logic [HOST_W-1:0] hostRdata,
  input  logic              sclkTick,
  input  logic              fsIn,
  output logic              fsOut,
  input  logic              txFull,
  input  logic              rxFull,
  input  logic              rxDone,
  input  logic [WORD_W-1:0] rxBuf,
  output logic              txMode,
  output serbufStrobeT      strobe
);
  localparam logic [PER_W-1:0] WORD_P = PER_W'(WORD_W);

  logic [CTRL_W-1:0] ctrlQ;
  logic [PER_W-1:0]  perQ;
  logic [PER_W-1:0]  effPer;
  logic [PER_W-1:0]  cnt;
  logic en, intSync, freeEff, tick, boundary, syncEvt;
  logic udf, ovf, clrUdf, clrOvf, hostTxWr, hostRxRd;
  logic unusedWdata;

  assign unusedWdata = ^hostWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      perQ  <= '0;
    end else if (hostWr) begin
      if (hostAddr == ADDR_CTRL) ctrlQ <= hostWdata[CTRL_W-1:0];
      if (hostAddr == ADDR_PER)  perQ  <= hostWdata[PER_W-1:0];
    end
  end

  assign en      = ctrlQ[BIT_EN];
  assign txMode  = ctrlQ[BIT_TX];
  assign intSync = ctrlQ[BIT_INTSYN];
  assign freeEff = ctrlQ[BIT_FREE] & ctrlQ[BIT_MC] & txMode;
  assign effPer  = (perQ < WORD_P) ? WORD_P : perQ;
  assign tick    = sclkTick & en;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (!en || !intSync) cnt <= '0;
    else if (tick) cnt <= (cnt >= effPer - PER_W'(1)) ? '0 : cnt + PER_W'(1);
  end

  assign boundary = tick & intSync & (cnt == '0);

  always_comb begin
    if (intSync) syncEvt = boundary & (txMode ? (txFull | freeEff) : 1'b1);
    else         syncEvt = tick & fsIn;
  end

  assign hostTxWr = en & hostWr & (hostAddr == ADDR_DATA);
  assign hostRxRd = en & hostRd & (hostAddr == ADDR_DATA);

  always_comb begin
    strobe.en       = en;
    strobe.tick     = tick;
    strobe.txLoad   = syncEvt & txMode;
    strobe.rxStart  = syncEvt & ~txMode;
    strobe.hostTxWr = hostTxWr;
    strobe.hostRxRd = hostRxRd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fsOut <= 1'b0;
    else if (!en) fsOut <= 1'b0;
    else if (syncEvt && intSync) fsOut <= 1'b1;
    else if (tick) fsOut <= 1'b0;
  end

  assign clrUdf = hostWr & (hostAddr == ADDR_STAT) & hostWdata[0];
  assign clrOvf = hostWr & (hostAddr == ADDR_STAT) & hostWdata[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      udf <= 1'b0;
      ovf <= 1'b0;
    end else if (!en) begin
      udf <= 1'b0;
      ovf <= 1'b0;
    end else begin
      if (strobe.txLoad && !txFull) udf <= 1'b1;
      else if (clrUdf) udf <= 1'b0;
      if (rxDone && rxFull && !hostRxRd) ovf <= 1'b1;
      else if (clrOvf) ovf <= 1'b0;
    end
  end

  always_comb begin
    unique case (hostAddr)
      ADDR_CTRL: hostRdata = HOST_W'(ctrlQ);
      ADDR_PER:  hostRdata = HOST_W'(perQ);
      ADDR_DATA: hostRdata = HOST_W'(rxBuf);
      default:   hostRdata = HOST_W'({ovf, udf, rxFull, txFull});
    endcase
  end

  AST_UDF_ON_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txLoad && !txFull |=> udf); // R7
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    en && udf && !clrUdf |=> udf); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    en && ovf && !clrOvf |=> ovf); // R10
  AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rstN)
    en && rxDone && rxFull && !hostRxRd |=> ovf); // R9
  AST_NO_SYNC_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fsOut) && $past(txMode) && $past(en) && !$past(freeEff) |-> $past(txFull)); // R5
  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !$past(en) |-> !fsOut && !udf && !ovf); // R10
endmodule

// File: rtl/serbuf_datapath.sv
module serbuf_datapath
  import serbuf_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  serbufStrobeT      strobe,
  input  logic              txMode,
  input  logic [WORD_W-1:0] wrWord,
  input  logic              sdIn,
  output logic              sdOut,
  output logic              txFull,
  output logic              rxFull,
  output logic              rxDone,
  output logic [WORD_W-1:0] rxBuf
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] txBuf;
  logic [WORD_W-1:0] txSr;
  logic [WORD_W-2:0] rxSr;
  logic [CNT_W-1:0]  rxLeft;

  // transmit holding buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf  <= '0;
      txFull <= 1'b0;
    end else if (!strobe.en) begin
      txFull <= 1'b0;
    end else if (strobe.hostTxWr) begin
      txBuf  <= wrWord;
      txFull <= 1'b1;
    end else if (strobe.txLoad) begin
      txFull <= 1'b0;
    end
  end

  // transmit shifter, empty load sends zeros
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txSr <= '0;
    else if (!strobe.en) txSr <= '0;
    else if (strobe.txLoad) txSr <= txFull ? txBuf : '0;
    else if (strobe.tick) txSr <= {txSr[WORD_W-2:0], 1'b0};
  end

  assign sdOut = txMode & txSr[WORD_W-1];

  // receive collector
  assign rxDone = strobe.tick & (rxLeft == CNT_W'(1)) & ~strobe.rxStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSr   <= '0;
      rxLeft <= '0;
    end else if (!strobe.en) begin
      rxLeft <= '0;
    end else if (strobe.rxStart) begin
      rxSr   <= {rxSr[WORD_W-3:0], sdIn};
      rxLeft <= CNT_W'(WORD_W - 1);
    end else if (strobe.tick && rxLeft != '0) begin
      rxSr   <= {rxSr[WORD_W-3:0], sdIn};
      rxLeft <= rxLeft - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf  <= '0;
      rxFull <= 1'b0;
    end else if (!strobe.en) begin
      rxFull <= 1'b0;
    end else if (rxDone) begin
      rxBuf  <= {rxSr, sdIn};
      rxFull <= 1'b1;
    end else if (strobe.hostRxRd) begin
      rxFull <= 1'b0;
    end
  end

  AST_TX_FILL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hostTxWr |=> txFull); // R2
  AST_TX_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txLoad && !strobe.hostTxWr |=> !txFull); // R2
  AST_UDF_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txLoad && !txFull |=> !sdOut); // R7
  AST_RX_FILL: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> rxFull); // R8
endmodule

// File: rtl/serbuf_top.sv
module serbuf_top
  import serbuf_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int PER_W  = 8,
  parameter int HOST_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [1:0]        hostAddr,
  input  logic [HOST_W-1:0] hostWdata,
  output logic [HOST_W-1:0] hostRdata,
  input  logic              sclkTick,
  input  logic              fsIn,
  output logic              fsOut,
  input  logic              sdIn,
  output logic              sdOut
);
  serbufStrobeT      strobe;
  logic              txMode, txFull, rxFull, rxDone;
  logic [WORD_W-1:0] rxBuf;

  serbuf_ctrl #(.WORD_W(WORD_W), .PER_W(PER_W), .HOST_W(HOST_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .sclkTick(sclkTick), .fsIn(fsIn), .fsOut(fsOut),
    .txFull(txFull), .rxFull(rxFull), .rxDone(rxDone), .rxBuf(rxBuf),
    .txMode(txMode), .strobe(strobe)
  );

  serbuf_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txMode(txMode),
    .wrWord(hostWdata[WORD_W-1:0]), .sdIn(sdIn), .sdOut(sdOut),
    .txFull(txFull), .rxFull(rxFull), .rxDone(rxDone), .rxBuf(rxBuf)
  );
endmodule

// File: tb/serbuf_top_tb.sv
`timescale 1ns/1ps
module serbuf_top_tb;
  localparam int WORD_W = 16;
  localparam int PER_W  = 8;
  localparam int HOST_W = 32;

  logic clk = 0, rstN = 0, hostWr = 0, hostRd = 0;
  logic [1:0] hostAddr = 0;
  logic [HOST_W-1:0] hostWdata = 0, hostRdata;
  logic sclkTick = 0, fsIn = 0, fsOut, sdIn = 0, sdOut;
  int checks = 0, errors = 0;

  serbuf_top #(.WORD_W(WORD_W), .PER_W(PER_W), .HOST_W(HOST_W)) u_dut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .sclkTick(sclkTick), .fsIn(fsIn),
    .fsOut(fsOut), .sdIn(sdIn), .sdOut(sdOut));

  always #2.5 clk = ~clk;

  // stimulus for strobe and serial input
  bit tickPh = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    tickPh = ~tickPh;
    sclkTick = tickPh;
    sdIn = lfsr[0];
    lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
  end

  // behavioural reference model
  int mCtrl = 0, mPer = 0, mTxBuf = 0, mRxBuf = 0, mCnt = 0, rxLeft = 0;
  bit mTxFull = 0, mRxFull = 0, mUdf = 0, mOvf = 0, mFs = 0;
  bit txq[$];
  bit rxq[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mPer = 0; mTxBuf = 0; mRxBuf = 0; mCnt = 0; rxLeft = 0;
      mTxFull = 0; mRxFull = 0; mUdf = 0; mOvf = 0; mFs = 0;
      txq.delete(); rxq.delete();
    end else begin
      bit en, tx, isync, fr, bnd, sync, rdNow, done, setU;
      int effPer, w;
      en = mCtrl[0]; tx = mCtrl[1]; isync = mCtrl[2]; fr = mCtrl[4] && mCtrl[3];
      if (!en) begin
        mTxFull = 0; mRxFull = 0; mUdf = 0; mOvf = 0; mFs = 0; mCnt = 0; rxLeft = 0;
        txq.delete();
      end else begin
        effPer = (mPer < WORD_W) ? WORD_W : mPer;
        bnd = sclkTick && isync && mCnt == 0;
        if (isync) sync = tx ? (bnd && (mTxFull || fr)) : bnd;
        else sync = sclkTick && fsIn;
        if (!isync) mCnt = 0;
        else if (sclkTick) mCnt = (mCnt >= effPer - 1) ? 0 : mCnt + 1;
        rdNow = hostRd && hostAddr == 2;
        done = 0; setU = 0;
        if (tx) begin
          if (sync) begin
            txq.delete();
            for (int i = WORD_W - 1; i >= 0; i--) txq.push_back(mTxFull ? mTxBuf[i] : 1'b0);
            if (!mTxFull) setU = 1;
            mTxFull = 0;
          end else if (sclkTick && txq.size() > 0) void'(txq.pop_front());
        end else begin
          if (sync) begin
            rxq.delete(); rxq.push_back(sdIn); rxLeft = WORD_W - 1;
          end else if (sclkTick && rxLeft > 0) begin
            rxq.push_back(sdIn); rxLeft--;
            if (rxLeft == 0) done = 1;
          end
        end
        if (sync && isync) mFs = 1; else if (sclkTick) mFs = 0;
        if (hostWr && hostAddr == 3 && hostWdata[0]) mUdf = 0;
        if (setU) mUdf = 1;
        if (hostWr && hostAddr == 3 && hostWdata[1]) mOvf = 0;
        if (done && mRxFull && !rdNow) mOvf = 1;
        if (done) begin
          w = 0;
          foreach (rxq[i]) w = (w << 1) | int'(rxq[i]);
          mRxBuf = w; mRxFull = 1;
        end else if (rdNow) mRxFull = 0;
        if (hostWr && hostAddr == 2) begin mTxBuf = hostWdata[15:0]; mTxFull = 1; end
      end
      if (hostWr && hostAddr == 0) mCtrl = hostWdata & 32'h1F;
      if (hostWr && hostAddr == 1) mPer = hostWdata & 32'hFF;
    end
  end

  // per-cycle comparison of pins
  always @(negedge clk) begin
    if (rstN) begin
      bit expSd;
      expSd = (mCtrl[1] && txq.size() > 0) ? txq[0] : 1'b0;
      checks++;
      if (sdOut !== expSd) begin
        errors++; $display("FAIL R3 sdOut actual %b expected %b at %0t", sdOut, expSd, $time);
      end
      checks++;
      if (fsOut !== mFs) begin
        errors++; $display("FAIL R4 fsOut actual %b expected %b at %0t", fsOut, mFs, $time);
      end
    end
  end

  function automatic int modelReg(input int a);
    case (a)
      0: return mCtrl;
      1: return mPer;
      2: return mRxBuf;
      default: return {mOvf, mUdf, mRxFull, mTxFull};
    endcase
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk); hostAddr = a[1:0]; hostWdata = d; hostWr = 1;
    @(negedge clk); hostWr = 0;
  endtask

  // compare a read with the model and optionally with fixed bits
  task automatic rd(input int a, input int mask, input int val, input string tag);
    int exp;
    @(negedge clk); hostAddr = a[1:0]; hostRd = 1; #1;
    exp = modelReg(a);
    checks++;
    if (hostRdata !== exp) begin
      errors++; $display("FAIL %s read %0d actual %h expected %h", tag, a, hostRdata, exp);
    end
    if (mask != 0) begin
      checks++;
      if ((hostRdata & mask) !== val) begin
        errors++; $display("FAIL %s read %0d bits actual %h expected %h", tag, a, hostRdata & mask, val);
      end
    end
    @(negedge clk); hostRd = 0;
  endtask

  task automatic extSync();
    @(negedge clk); fsIn = 1;
    forever begin @(posedge clk); if (sclkTick) break; end
    @(negedge clk); fsIn = 0;
  endtask

  task automatic countRises(input int cycles, input int exp, input string tag);
    int n = 0; bit prev = fsOut;
    repeat (cycles) begin @(negedge clk); if (fsOut && !prev) n++; prev = fsOut; end
    checks++;
    if (n != exp) begin errors++; $display("FAIL %s sync count actual %0d expected %0d", tag, n, exp); end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    // R1 reset state
    checks++;
    if (sdOut !== 0 || fsOut !== 0) begin errors++; $display("FAIL R1 pins actual %b%b expected 00", sdOut, fsOut); end
    rd(0, 32'h1F, 0, "R1"); rd(1, 32'hFF, 0, "R1"); rd(3, 32'hF, 0, "R1");
    // R2 R3 data-dependent internal transmit
    wr(1, 20); wr(0, 32'h7); wr(2, 32'hA5C3);
    repeat (100) @(negedge clk);
    rd(3, 32'hF, 0, "R2");
    countRises(200, 0, "R5");
    rd(3, 32'h4, 0, "R5");
    wr(2, 32'h3C5A);
    repeat (100) @(negedge clk);
    rd(3, 32'h1, 0, "R2");
    // R2 write while disabled
    wr(0, 0); wr(2, 32'h1234); rd(3, 32'hF, 0, "R2");
    // R5 free bit without multichannel
    wr(0, 32'h17); countRises(200, 0, "R5"); rd(3, 32'h4, 0, "R5");
    // R6 R4 free-running
    wr(0, 0); wr(0, 32'h1F);
    @(posedge fsOut); @(negedge clk);
    countRises(390, 9, "R4");
    rd(3, 32'h4, 32'h4, "R6");
    wr(1, 5); @(posedge fsOut); @(negedge clk);
    countRises(310, 9, "R4");
    // R7 R10 external transmit
    wr(0, 0); wr(0, 32'h3); wr(2, 32'h8001);
    extSync();
    checks++;
    if (sdOut !== 1'b1) begin errors++; $display("FAIL R3 msb actual %b expected 1", sdOut); end
    rd(3, 32'h1, 0, "R2");
    repeat (40) @(negedge clk);
    extSync();
    repeat (4) @(negedge clk);
    rd(3, 32'h4, 32'h4, "R7");
    wr(3, 0); rd(3, 32'h4, 32'h4, "R10");
    wr(0, 32'h3); rd(3, 32'h4, 32'h4, "R10");
    wr(3, 1); rd(3, 32'h4, 0, "R10");
    // R8 R9 receive
    wr(0, 0); wr(1, 40); wr(0, 32'h5);
    repeat (50) @(negedge clk);
    rd(3, 32'h2, 32'h2, "R8");
    rd(2, 0, 0, "R8");
    rd(3, 32'h2, 0, "R8");
    repeat (200) @(negedge clk);
    rd(3, 32'hA, 32'hA, "R9");
    rd(2, 0, 0, "R9");
    wr(3, 0); rd(3, 32'h8, 32'h8, "R10");
    wr(0, 0); repeat (2) @(negedge clk);
    rd(3, 32'hF, 0, "R10");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule